// File: doc/BRIEF.md
# Feed Controller Interrupt Register Unit

This block holds the interrupt bookkeeping registers of a cryptographic data-feed controller. It has four DMA-related interrupt sources: the block-receive channel, the block-transmit channel, the hash-receive channel and the public-key channel. A one-cycle pulse on a source input latches a pending bit whether or not that source is enabled. Software owns a 4-bit enable mask, but it cannot write the mask directly. Enabling a source and disabling a source go to two separate addresses, and each takes a write-one-per-bit form.

Pending bits are cleared by writing ones to the pending address. Because of this, a handler can read the raw status word and write the same value back to acknowledge exactly what it saw. The interrupt line is the OR of all pending bits that are also enabled. The same register port also reads back the live full and empty flags of the four channel FIFOs as interleaved bit pairs.

The bus port is a plain single-cycle register port. A write is taken on the clock edge when `reg_wr` is high. `reg_rdata` is a combinational function of `reg_addr` and the current register state.

Top module: `feed_irq_unit`

## Requirements
- R1: After reset, the enable mask and all pending bits are zero, every register read returns 0 (FIFO inputs low), and `irq` is low.
- R2: A write to offset 0x04 sets every enable bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R3: A write to offset 0x08 clears every enable bit whose write-data bit is 1 and leaves the bits written with 0 unchanged. Reads of offset 0x04 and offset 0x08 both return the enable mask in bits 3:0.
- R4: A 1 on `src_evt[i]` at a clock edge sets pending bit i regardless of the enable mask. Source bit positions are: 3 block-receive, 2 block-transmit, 1 hash-receive, 0 public-key. Offset 0x00 reads all pending bits, unmasked, in bits 3:0.
- R5: A write to offset 0x0C clears every pending bit whose write-data bit is 1 and leaves the bits written with 0 unchanged. Offset 0x0C reads the pending bits AND the enable mask.
- R6: When a source event and a clearing write hit the same pending bit at one edge, the bit ends up set.
- R7: `irq` is high exactly while some bit is both pending and enabled. With the default combinational output, `irq` follows the register state in the same cycle.
- R8: Offset 0x10 reads channel i's FIFO full flag at bit 2i+1 and its empty flag at bit 2i, taken live from the inputs. Bits above 7 read 0.
- R9: Writes to offsets 0x00 and 0x10 and to any unmapped address change no state. Unmapped reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, taken at the clock edge |
| reg_addr | input | ADDR_W (8) | Byte address of the register |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr` (combinational) |
| src_evt | input | NUM_SRC (4) | One-cycle event pulses per source |
| fifo_full | input | NUM_SRC (4) | FIFO full flag per channel |
| fifo_empty | input | NUM_SRC (4) | FIFO empty flag per channel |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, the register-update rules:
- a set write leaves all written bits enabled;
- a clear write leaves them disabled;
- an event always leaves its pending bit set, even against a simultaneous clear;
- a clear removes only bits that had no simultaneous event;
- pending state holds when nothing touches it;
- the interrupt line never rises with an empty enable mask.

Only the bench scenarios show the rest: the address decode and read-back values, the masked view at the pending address, the FIFO bit interleave, and that writes to read-only or unmapped addresses leave every register unchanged.

// File: rtl/feed_irq_pkg.sv
package feed_irq_pkg;

   localparam logic [7:0] OFS_RAW   = 8'h00;
   localparam logic [7:0] OFS_ENSET = 8'h04;
   localparam logic [7:0] OFS_ENCLR = 8'h08;
   localparam logic [7:0] OFS_PEND  = 8'h0C;
   localparam logic [7:0] OFS_FIFO  = 8'h10;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_RAW,
      SEL_ENSET,
      SEL_ENCLR,
      SEL_PEND,
      SEL_FIFO
   } reg_sel_e;

   function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
      case (ofs)
         OFS_RAW:   return SEL_RAW;
         OFS_ENSET: return SEL_ENSET;
         OFS_ENCLR: return SEL_ENCLR;
         OFS_PEND:  return SEL_PEND;
         OFS_FIFO:  return SEL_FIFO;
         default:   return SEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/irq_enable_mask.sv
module irq_enable_mask #(
   parameter int NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_we,
   input  logic               clr_we,
   input  logic [NUM_SRC-1:0] wbits,
   output logic [NUM_SRC-1:0] en_q
);
   logic [NUM_SRC-1:0] set_bits, clr_bits, en_d;

   assign set_bits = set_we ? wbits : '0;
   assign clr_bits = clr_we ? wbits : '0;
   assign en_d     = (en_q | set_bits) & ~clr_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_d;
   end

   // R2: every bit written as one to the set address is enabled afterwards
   assert_enset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((en_q & $past(wbits)) == $past(wbits)));

   // R3: every bit written as one to the clear address is disabled afterwards
   assert_enclr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((en_q & $past(wbits)) == '0));

   // R2, R3: without a write the mask holds
   assert_enhold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(en_q));

endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
   parameter int NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_we,
   input  logic [NUM_SRC-1:0] wbits,
   input  logic [NUM_SRC-1:0] evt,
   output logic [NUM_SRC-1:0] pend_q
);
   logic [NUM_SRC-1:0] clr_bits;
   logic [NUM_SRC-1:0] pend_d;

   assign clr_bits = clr_we ? wbits : '0;

   // per-bit update: an arriving event outranks a clearing write
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      always_comb begin
         if (evt[i])           pend_d[i] = 1'b1;
         else if (clr_bits[i]) pend_d[i] = 1'b0;
         else                  pend_d[i] = pend_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

   // R4, R6: an event always leaves its pending bit set
   assert_evt_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((pend_q & $past(evt)) == $past(evt)));

   // R5: ones written to the pending address clear bits that had no event
   assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((pend_q & $past(wbits) & ~$past(evt)) == '0));

   // R5: without event or write the pending bits hold
   assert_pendhold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_we && evt == '0) |=> $stable(pend_q));

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
   import feed_irq_pkg::*;
#(
   parameter int NUM_SRC = 4,
   parameter int DATA_W  = 32
) (
   input  reg_sel_e           sel,
   input  logic [NUM_SRC-1:0] pend,
   input  logic [NUM_SRC-1:0] en,
   input  logic [NUM_SRC-1:0] full,
   input  logic [NUM_SRC-1:0] empty,
   output logic [DATA_W-1:0]  rdata
);
   localparam int FIFO_W = 2 * NUM_SRC;

   logic [FIFO_W-1:0] fifo_word;

   // channel i: full at bit 2i+1, empty at bit 2i
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_fifo
      assign fifo_word[2*i+1] = full[i];
      assign fifo_word[2*i]   = empty[i];
   end

   always_comb begin
      rdata = '0;
      case (sel)
         SEL_RAW:   rdata[NUM_SRC-1:0] = pend;
         SEL_ENSET,
         SEL_ENCLR: rdata[NUM_SRC-1:0] = en;
         SEL_PEND:  rdata[NUM_SRC-1:0] = pend & en;
         SEL_FIFO:  rdata[FIFO_W-1:0]  = fifo_word;
         default:   rdata = '0;
      endcase
   end

endmodule

// File: rtl/feed_irq_unit.sv
module feed_irq_unit
   import feed_irq_pkg::*;
#(
   parameter int NUM_SRC = 4,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [NUM_SRC-1:0] src_evt,
   input  logic [NUM_SRC-1:0] fifo_full,
   input  logic [NUM_SRC-1:0] fifo_empty,
   output logic               irq
);
   localparam int FIFO_W = 2 * NUM_SRC;

   initial begin
      assert (FIFO_W <= DATA_W) else $error("FIFO word wider than data bus");
      assert (ADDR_W >= 8) else $error("address must hold 8 offset bits");
      assert (NUM_SRC >= 1) else $error("need at least one source");
   end

   reg_sel_e           sel;
   logic               hi_zero;
   logic [NUM_SRC-1:0] wbits;
   logic [NUM_SRC-1:0] en_mask;
   logic [NUM_SRC-1:0] pend;
   logic               irq_next;
   logic               unused_hi;

   assign hi_zero   = (reg_addr >> 8) == '0;
   assign sel       = hi_zero ? decode_ofs(reg_addr[7:0]) : SEL_NONE;
   assign wbits     = reg_wdata[NUM_SRC-1:0];
   assign unused_hi = ^reg_wdata;

   irq_enable_mask #(.NUM_SRC(NUM_SRC)) u_enable (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (reg_wr && sel == SEL_ENSET),
      .clr_we (reg_wr && sel == SEL_ENCLR),
      .wbits  (wbits),
      .en_q   (en_mask)
   );

   irq_pending_bank #(.NUM_SRC(NUM_SRC)) u_pending (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_we (reg_wr && sel == SEL_PEND),
      .wbits  (wbits),
      .evt    (src_evt),
      .pend_q (pend)
   );

   irq_read_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rmux (
      .sel   (sel),
      .pend  (pend),
      .en    (en_mask),
      .full  (fifo_full),
      .empty (fifo_empty),
      .rdata (reg_rdata)
   );

   assign irq_next = |(pend & en_mask);

   if (IRQ_REG) begin : g_irq_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_next;
      end
   end else begin : g_irq_comb
      assign irq = irq_next;

      // R7: the line is never up while the enable mask is empty
      assert_irq_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> (en_mask != '0));
   end

endmodule

// File: tb/tb_feed_irq_unit.sv
`timescale 1ns/1ps
module tb_feed_irq_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  src_evt = '0;
   logic [3:0]  fifo_full = '0;
   logic [3:0]  fifo_empty = '0;
   logic        irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   feed_irq_unit dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_evt(src_evt),
      .fifo_full(fifo_full), .fifo_empty(fifo_empty), .irq(irq)
   );

   // vector: {op[1:0], addr[7:0], value[31:0], req[3:0]}
   // op 0 = write, 1 = read check, 2 = event pulse, 3 = irq check
   localparam int NV = 30;
   localparam logic [45:0] VEC [NV] = '{
      {2'd0, 8'h04, 32'h5, 4'd2},  // R2 set bits 2,0
      {2'd1, 8'h04, 32'h5, 4'd2},
      {2'd1, 8'h08, 32'h5, 4'd3},  // R3 clear address reads mask
      {2'd0, 8'h04, 32'h0, 4'd2},  // R2 zeros no effect
      {2'd1, 8'h04, 32'h5, 4'd2},
      {2'd0, 8'h08, 32'h4, 4'd3},  // R3 clear bit 2
      {2'd1, 8'h08, 32'h1, 4'd3},
      {2'd0, 8'h08, 32'h0, 4'd3},  // R3 zeros no effect
      {2'd1, 8'h04, 32'h1, 4'd3},
      {2'd2, 8'h00, 32'hA, 4'd4},  // R4 events on disabled sources
      {2'd1, 8'h00, 32'hA, 4'd4},
      {2'd1, 8'h0C, 32'h0, 4'd5},  // R5 masked view
      {2'd3, 8'h00, 32'h0, 4'd7},  // R7 nothing enabled is pending
      {2'd2, 8'h00, 32'h1, 4'd4},
      {2'd1, 8'h00, 32'hB, 4'd4},
      {2'd1, 8'h0C, 32'h1, 4'd5},
      {2'd3, 8'h00, 32'h1, 4'd7},  // R7
      {2'd0, 8'h0C, 32'h0, 4'd5},  // R5 zeros no effect
      {2'd1, 8'h00, 32'hB, 4'd5},
      {2'd0, 8'h0C, 32'h3, 4'd5},  // R5 clear bits 1,0
      {2'd1, 8'h00, 32'h8, 4'd5},
      {2'd3, 8'h00, 32'h0, 4'd7},  // R7
      {2'd0, 8'h00, 32'hF, 4'd9},  // R9 status address read-only
      {2'd0, 8'h10, 32'hFF, 4'd9}, // R9 FIFO address read-only
      {2'd0, 8'h14, 32'hF, 4'd9},  // R9 unmapped
      {2'd1, 8'h00, 32'h8, 4'd9},
      {2'd1, 8'h04, 32'h1, 4'd9},
      {2'd1, 8'h14, 32'h0, 4'd9},
      {2'd0, 8'h0C, 32'h8, 4'd5},
      {2'd1, 8'h00, 32'h0, 4'd5}
   };

   task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] e);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; src_evt = e;
      @(posedge clk); #1;
      reg_wr = 1'b0; reg_wdata = '0; src_evt = '0;
   endtask

   task automatic evt(input logic [3:0] e);
      src_evt = e;
      @(posedge clk); #1;
      src_evt = '0;
   endtask

   task automatic rd(input int req, input logic [7:0] a, input logic [31:0] exp);
      reg_addr = a; #1;
      check(req, reg_rdata, exp);
   endtask

   initial begin
      #1600000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset state
      rd(1, 8'h00, 32'h0);
      rd(1, 8'h04, 32'h0);
      rd(1, 8'h0C, 32'h0);
      rd(1, 8'h10, 32'h0);
      check(1, {31'h0, irq}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         logic [1:0]  op;
         logic [7:0]  a;
         logic [31:0] v;
         int          rq;
         op = VEC[i][45:44]; a = VEC[i][43:36]; v = VEC[i][35:4]; rq = int'(VEC[i][3:0]);
         case (op)
            2'd0: wr(a, v, 4'h0);
            2'd1: rd(rq, a, v);
            2'd2: evt(v[3:0]);
            default: begin #1; check(rq, {31'h0, irq}, v); end
         endcase
      end

      // R6 event against clearing write on the same bit
      wr(8'h08, 32'hF, 4'h0);
      evt(4'h4);
      wr(8'h0C, 32'h4, 4'h4);
      rd(6, 8'h00, 32'h4);
      // R6 clear of bit 2 with event on bit 0
      wr(8'h0C, 32'h4, 4'h1);
      rd(6, 8'h00, 32'h1);

      // R7 enabling an already pending source raises irq, disabling drops it
      #1 check(7, {31'h0, irq}, 32'h0);
      wr(8'h04, 32'h1, 4'h0);
      #1 check(7, {31'h0, irq}, 32'h1);
      wr(8'h08, 32'h1, 4'h0);
      #1 check(7, {31'h0, irq}, 32'h0);
      rd(7, 8'h00, 32'h1);

      // R8 FIFO flag interleave, live
      fifo_full = 4'b1001; fifo_empty = 4'b0110;
      rd(8, 8'h10, 32'h96);
      fifo_full = 4'b0000; fifo_empty = 4'b1111;
      rd(8, 8'h10, 32'h55);
      fifo_full = 4'b1111; fifo_empty = 4'b0000;
      rd(8, 8'h10, 32'hAA);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule